// File: doc/BRIEF.md
# Daisy-Chained Serial Converter Readout Controller

This controller sits on the host side of a chain of serial 16-bit converters that share one three-wire link. The converters report completion over that same link. On a start request it raises the convert strobe while the serial clock is parked high. This places the whole chain in chained mode with a completion indicator. The controller then watches the data line of the converter nearest the host. That line reads low while conversion is in progress and rises once every converter in the chain has finished.

After that rising edge, the controller produces `16*NUM_DEV+1` serial clock periods. It samples the data line at each falling edge. The first sample is the completion bit and is thrown away. The remaining bits are assembled most significant bit first into `NUM_DEV` parallel words, each delivered with a one-cycle valid strobe and an index. A one-cycle done pulse follows the last word. If no completion edge appears within `TIMEOUT` cycles, the controller raises an error flag and drops the convert strobe.

Top module: `chain_adc_reader`

## Requirements
- R1: Out of reset, and whenever the controller is idle (`busy_o` low), `cnv_o` is low and `sck_o` is high.
- R2: `cnv_o` rises only while `sck_o` is high. A `start_i` pulse sampled in idle begins a conversion.
- R3: `cnv_o` stays high without a break from the accepted start through the final serial clock period of the readout.
- R4: While waiting for conversion, a low-to-high transition on `sdo_i` ends the wait and starts the readout.
- R5: Each readout produces exactly `16*NUM_DEV+1` falling edges on `sck_o`. Each high phase and each low phase lasts `CLK_DIV` system cycles.
- R6: `sdo_i` is sampled in the system cycle in which `sck_o` falls. The first sample (the completion bit) is discarded. Every following group of 16 samples forms one word, with the first sample as bit 15.
- R7: Exactly `NUM_DEV` words are delivered per readout, each with a one-cycle `word_valid_o`. `word_idx_o` counts 0, 1, … in arrival order, so index 0 is the converter nearest the host.
- R8: `done_o` is a one-cycle pulse that follows the last word of a readout. After it the controller is idle with `cnv_o` low.
- R9: If no rising edge on `sdo_i` arrives within `TIMEOUT` cycles of the start, `timeout_o` goes high, `cnv_o` returns low, and no serial clock edge is produced. `timeout_o` stays high until the next accepted start clears it.
- R10: A `start_i` pulse while the controller is busy is ignored. It neither restarts the sequence nor adds serial clock edges or words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion and readout |
| sdo_i | input | 1 | Serial data from the converter nearest the host |
| cnv_o | output | 1 | Convert strobe to all converters |
| sck_o | output | 1 | Serial clock to all converters |
| word_o | output | WORD_W | Assembled result word |
| word_idx_o | output | IDX_W | Position of the word in the chain (0 = nearest) |
| word_valid_o | output | 1 | One-cycle strobe qualifying word_o and word_idx_o |
| done_o | output | 1 | One-cycle pulse after the last word |
| timeout_o | output | 1 | Completion edge missing; held until the next start |
| busy_o | output | 1 | Sequence in progress |

## Verification
Embedded properties check the following on every cycle:
- the convert strobe rises only with the clock parked high;
- the strobe holds through readout;
- the serial clock is parked while idle;
- the falling-edge count never passes its bound;
- word indices stay in range;
- done is a single-cycle pulse;
- the strobe falls on a timeout;
- a running readout never re-enters conversion.

Only the bench scenarios can show the rest. These are the exact number of falling edges per readout, bit-exact word assembly and ordering against a shifting chain model with random conversion delays and data, the ignored mid-sequence start requests, and the timeout path followed by a clean recovery.

// File: rtl/chain_rd_pkg.sv
package chain_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_READ = 2'd2
  } seq_state_e;
endpackage

// File: rtl/chain_rd_sck.sv
// Serial clock generator: parks high, toggles every CLK_DIV cycles while
// running, flags the cycle in which a falling edge is launched.
module chain_rd_sck #(
  parameter int CLK_DIV     = 2,
  parameter int TOTAL_FALLS = 49
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sck_o,
  output logic fall_o,
  output logic finish_o
);
  localparam int PH_W  = $clog2(CLK_DIV + 1);
  localparam int CNT_W = $clog2(TOTAL_FALLS + 1);

  logic [PH_W-1:0]  ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sck_q, sck_d;
  logic             tick;

  always_comb begin
    tick     = run_i && (ph_q == PH_W'(CLK_DIV - 1));
    fall_o   = tick && sck_q;
    finish_o = tick && !sck_q && (cnt_q == CNT_W'(TOTAL_FALLS));
    ph_d     = ph_q;
    sck_d    = sck_q;
    cnt_d    = cnt_q;
    if (!run_i) begin
      ph_d  = '0;
      sck_d = 1'b1;
      cnt_d = '0;
    end else if (tick) begin
      ph_d  = '0;
      sck_d = ~sck_q;
      if (sck_q) cnt_d = cnt_q + 1'b1;
    end else begin
      ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      sck_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      sck_q <= sck_d;
      cnt_q <= cnt_d;
    end
  end

  assign sck_o = sck_q;

  p_fall_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(TOTAL_FALLS));
endmodule

// File: rtl/chain_rd_asm.sv
// Word assembler: drops the first sampled bit, packs the rest MSB first.
module chain_rd_asm #(
  parameter int NUM_DEV = 3,
  parameter int WORD_W  = 16,
  parameter int IDX_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              bit_stb_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              valid_o
);
  localparam int BC_W = $clog2(WORD_W);

  logic              first_q, first_d;
  logic [BC_W-1:0]   bcnt_q, bcnt_d;
  logic [WORD_W-1:0] sh_q, sh_d, word_q, word_d;
  logic [IDX_W-1:0]  widx_q, widx_d, oidx_q, oidx_d;
  logic              valid_q, valid_d;

  always_comb begin
    first_d = first_q;
    bcnt_d  = bcnt_q;
    sh_d    = sh_q;
    word_d  = word_q;
    widx_d  = widx_q;
    oidx_d  = oidx_q;
    valid_d = 1'b0;
    if (clear_i) begin
      first_d = 1'b0;
      bcnt_d  = '0;
      widx_d  = '0;
    end else if (bit_stb_i) begin
      if (!first_q) begin
        first_d = 1'b1;
      end else begin
        sh_d = {sh_q[WORD_W-2:0], bit_i};
        if (bcnt_q == BC_W'(WORD_W - 1)) begin
          bcnt_d  = '0;
          valid_d = 1'b1;
          word_d  = sh_d;
          oidx_d  = widx_q;
          widx_d  = widx_q + 1'b1;
        end else begin
          bcnt_d = bcnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b0;
      bcnt_q  <= '0;
      sh_q    <= '0;
      word_q  <= '0;
      widx_q  <= '0;
      oidx_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      first_q <= first_d;
      bcnt_q  <= bcnt_d;
      sh_q    <= sh_d;
      word_q  <= word_d;
      widx_q  <= widx_d;
      oidx_q  <= oidx_d;
      valid_q <= valid_d;
    end
  end

  assign word_o  = word_q;
  assign idx_o   = oidx_q;
  assign valid_o = valid_q;

  p_idx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (32'(oidx_q) < NUM_DEV));
endmodule

// File: rtl/chain_rd_seq.sv
// Sequencer: idle -> conversion wait (with timeout) -> readout.
module chain_rd_seq
  import chain_rd_pkg::*;
#(
  parameter int TIMEOUT = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       rise_i,
  input  logic       finish_i,
  output seq_state_e state_o,
  output logic       cnv_o,
  output logic       done_o,
  output logic       timeout_o
);
  localparam int TO_W = $clog2(TIMEOUT + 1);

  seq_state_e      st_q, st_d;
  logic [TO_W-1:0] tcnt_q, tcnt_d;
  logic            cnv_q, cnv_d, done_q, done_d, to_q, to_d;

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    done_d = 1'b0;
    to_d   = to_q;
    case (st_q)
      ST_IDLE: begin
        tcnt_d = '0;
        if (start_i) begin
          st_d = ST_CONV;
          to_d = 1'b0;
        end
      end
      ST_CONV: begin
        if (rise_i) begin
          st_d = ST_READ;
        end else if (tcnt_q == TO_W'(TIMEOUT - 1)) begin
          st_d = ST_IDLE;
          to_d = 1'b1;
        end else begin
          tcnt_d = tcnt_q + 1'b1;
        end
      end
      ST_READ: begin
        if (finish_i) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    cnv_d = (st_d != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tcnt_q <= '0;
      cnv_q  <= 1'b0;
      done_q <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
      cnv_q  <= cnv_d;
      done_q <= done_d;
      to_q   <= to_d;
    end
  end

  assign state_o   = st_q;
  assign cnv_o     = cnv_q;
  assign done_o    = done_q;
  assign timeout_o = to_q;

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_timeout_cnv_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_q) |-> !cnv_q);
  p_read_cnv_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_READ) |-> cnv_q);
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_READ) |=> (st_q != ST_CONV));
endmodule

// File: rtl/chain_adc_reader.sv
module chain_adc_reader
  import chain_rd_pkg::*;
#(
  parameter int NUM_DEV = 3,
  parameter int WORD_W  = 16,
  parameter int CLK_DIV = 2,
  parameter int TIMEOUT = 100,
  localparam int IDX_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sdo_i,
  output logic              cnv_o,
  output logic              sck_o,
  output logic [WORD_W-1:0] word_o,
  output logic [IDX_W-1:0]  word_idx_o,
  output logic              word_valid_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              busy_o
);
  localparam int TOTAL_FALLS = WORD_W * NUM_DEV + 1;

  seq_state_e state;
  logic       sdo_q, sdo_rise, fall, finish, run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sdo_q <= 1'b0;
    else        sdo_q <= sdo_i;
  end

  assign sdo_rise = (state == ST_CONV) && sdo_i && !sdo_q;
  assign run      = (state == ST_READ);
  assign busy_o   = (state != ST_IDLE);

  chain_rd_seq #(.TIMEOUT(TIMEOUT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rise_i(sdo_rise),
    .finish_i(finish), .state_o(state), .cnv_o(cnv_o), .done_o(done_o),
    .timeout_o(timeout_o)
  );

  chain_rd_sck #(.CLK_DIV(CLK_DIV), .TOTAL_FALLS(TOTAL_FALLS)) u_sck (
    .clk(clk), .rst_n(rst_n), .run_i(run), .sck_o(sck_o), .fall_o(fall),
    .finish_o(finish)
  );

  chain_rd_asm #(.NUM_DEV(NUM_DEV), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .clear_i(!run), .bit_stb_i(fall), .bit_i(sdo_i),
    .word_o(word_o), .idx_o(word_idx_o), .valid_o(word_valid_o)
  );

  p_cnv_rise_sck_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_o) |-> sck_o);
  p_idle_sck_parked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> sck_o);
endmodule

// File: tb/chain_adc_reader_test.sv
module chain_adc_reader_test;
  localparam int N   = 3;
  localparam int W   = 16;
  localparam int DIV = 2;
  localparam int TO  = 100;
  localparam int TOT = W * N + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic ready = 1'b0;
  logic [TOT-1:0] chain_bits = '0;
  logic sdo_i;
  logic cnv_o, sck_o, word_valid_o, done_o, timeout_o, busy_o;
  logic [W-1:0] word_o;
  logic [1:0]   word_idx_o;

  int checks = 0, errors = 0;
  int falls = 0, rises = 0, nwords = 0, ndone = 0;
  logic [W-1:0] exp_w [N];
  logic [W-1:0] got_w [N];

  always #4 clk = ~clk;

  assign sdo_i = ready ? chain_bits[TOT-1] : 1'b0;

  chain_adc_reader #(.NUM_DEV(N), .WORD_W(W), .CLK_DIV(DIV), .TIMEOUT(TO)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sdo_i(sdo_i), .cnv_o(cnv_o),
    .sck_o(sck_o), .word_o(word_o), .word_idx_o(word_idx_o),
    .word_valid_o(word_valid_o), .done_o(done_o), .timeout_o(timeout_o),
    .busy_o(busy_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // chain model: shift on each serial clock fall, after a hold delay
  always @(negedge sck_o) if (rst_n && ready) begin
    falls++;
    chain_bits <= #1 {chain_bits[TOT-2:0], 1'b0};
  end
  always @(negedge sck_o) if (rst_n && busy_o)
    check(cnv_o == 1'b1, "R3 cnv high at sck fall", cnv_o, 1);
  always @(posedge cnv_o) if (rst_n) begin
    rises++;
    check(sck_o == 1'b1, "R2 sck high at cnv rise", sck_o, 1);
  end
  always @(negedge cnv_o) ready = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (word_valid_o) begin
      if (int'(word_idx_o) < N) got_w[word_idx_o] = word_o;
      check(int'(word_idx_o) == nwords, "R7 word index order", word_idx_o, nwords);
      nwords++;
    end
    if (done_o) begin
      ndone++;
      check(nwords == N, "R8 done after last word", nwords, N);
    end
  end

  function automatic logic [TOT-1:0] pack_chain();
    logic [TOT-1:0] v;
    v = '0;
    v[TOT-1] = 1'b1;
    for (int k = 0; k < N; k++) v[TOT-2-k*W -: W] = exp_w[k];
    return v;
  endfunction

  task automatic run_one(input int delay, input bit poke_start);
    falls = 0; rises = 0; nwords = 0; ndone = 0;
    chain_bits = pack_chain();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int i = 0; i < delay; i++) begin
      @(negedge clk);
      if (poke_start && i == 2) start_i = 1'b1;
      else start_i = 1'b0;
    end
    start_i = 1'b0;
    ready = 1'b1;
    for (int i = 0; i < 2000 && !done_o; i++) begin
      @(negedge clk);
      if (poke_start && i == 40) start_i = 1'b1;
      else start_i = 1'b0;
    end
    start_i = 1'b0;
    check(done_o == 1'b1, "R8 done seen", done_o, 1);
    @(negedge clk);
    check(done_o == 1'b0, "R8 done one cycle", done_o, 0);
    repeat (6) @(negedge clk);
    check(falls == TOT, "R5 fall count", falls, TOT);
    check(nwords == N, "R7 word count", nwords, N);
    check(ndone == 1, "R8 single done", ndone, 1);
    check(rises == 1, "R10 single cnv rise", rises, 1);
    check(cnv_o == 1'b0 && sck_o == 1'b1 && !busy_o, "R1 idle after run",
          {cnv_o, sck_o, busy_o}, 3'b010);
    check(timeout_o == 1'b0, "R9 no timeout flag", timeout_o, 0);
    for (int k = 0; k < N; k++)
      check(got_w[k] == exp_w[k], "R6 word data", got_w[k], exp_w[k]);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check(cnv_o == 1'b0 && sck_o == 1'b1, "R1 reset lines", {cnv_o, sck_o}, 2'b01);
    check(!busy_o && !timeout_o && !done_o && !word_valid_o, "R1 reset flags",
          {busy_o, timeout_o, done_o, word_valid_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed patterns
    exp_w[0] = 16'hFFFF; exp_w[1] = 16'h0000; exp_w[2] = 16'h8001;
    run_one(1, 1'b0);                          // R4 shortest wait
    exp_w[0] = 16'hA5C3; exp_w[1] = 16'h0001; exp_w[2] = 16'h8000;
    run_one(TO - 3, 1'b0);                     // R4 near the timeout limit
    exp_w[0] = 16'h1234; exp_w[1] = 16'hFEDC; exp_w[2] = 16'h7FFE;
    run_one(10, 1'b1);                         // R10 starts while busy

    // timeout path (R9)
    rises = 0; falls = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (TO + 8) @(negedge clk);
    check(timeout_o == 1'b1, "R9 timeout flag", timeout_o, 1);
    check(cnv_o == 1'b0 && !busy_o, "R9 cnv low idle", {cnv_o, busy_o}, 0);
    check(falls == 0, "R9 no sck edges", falls, 0);
    check(sck_o == 1'b1, "R1 sck parked after timeout", sck_o, 1);

    // random runs; also confirm timeout flag cleared (R9)
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < N; k++) exp_w[k] = W'($urandom);
      run_one(1 + int'($urandom % 60), r[0]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule